// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block sits next to a small 8-bit microcontroller core and carries out entry into an interrupt. While idle it looks at a reset request, a vector of pending hardware sources, the core's global interrupt enable and a flag that says a conditional skip of the next instruction has not yet been resolved. When it accepts a request, it stores the current word program counter on a byte-wide descending stack, one byte per transfer, through a valid/ready write stream. The stack pointer is reported after every byte. When the last byte has been written, it loads the vector address into the program counter, clears the global enable and clears the one pending bit it served.

The stack write stream follows valid/ready rules. `st_valid` rises in the cycle after acceptance. `st_addr` and `st_data` stay constant while `st_valid` is high and `st_ready` is low. A byte counts as written on a clock edge where both are high. The memory side may hold `st_ready` low for any number of cycles, and the whole entry stretches by the same amount. The core applies the strobes it receives: `sp_we`/`sp_next`, `pc_we`/`pc_next`, `gie_clr` and `pend_clr`.

Vector spacing is set by the parameter `LONG_VEC`: two words when long jump/call is configured, one word otherwise. The number of stacked bytes is set by the program counter width `PC_W`.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `st_valid`, `sp_we`, `pc_we`, `gie_clr` and `rst_taken` are 0 and `pend_clr` is all zeros.
- R2: No request is accepted in a cycle where `skip_pend` is 1, even when `gie` is 1 and requests are present.
- R3: No request, reset or hardware, is accepted while `gie` is 0. A hardware request also needs at least one bit of `irq_pend` set.
- R4: A reset request takes precedence over pending hardware sources. It uses vector number 0, so `pc_next` is 0, `rst_taken` pulses with `pc_we`, and `pend_clr` stays all zeros.
- R5: For a hardware entry, the winner is the lowest-numbered set bit i of `irq_pend`. `pc_next` equals (i+1)×VS, where VS is 2 when `LONG_VEC`=1 and 1 otherwise. `pend_clr` has only bit i set.
- R6: The return address is written least significant byte first, to addresses sp, sp−1, sp−2, where sp is `sp_cur` at acceptance. The byte count is 3 for `PC_W` above 16, 2 for `PC_W` from 9 to 16, and 1 otherwise. The upper byte of a 3-byte push carries the PC bits above 15, zero-extended.
- R7: Each byte write is accompanied by `sp_we` = 1 with `sp_next` equal to that byte's address minus 1.
- R8: While `st_valid` is 1 and `st_ready` is 0, `st_addr` and `st_data` hold their values and `sp_we` stays 0.
- R9: `busy` is 1 from the cycle after acceptance through the program counter load cycle, and 0 in the cycle after that. Changes to the requests while busy do not alter the entry in progress.
- R10: The load cycle is a single cycle in which `pc_we` and `gie_clr` are both 1. It occurs exactly once per accepted entry.
- R11: The first byte is offered in the cycle after acceptance. The load cycle follows directly after the edge that writes the last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rst_req | input | 1 | Reset-type request |
| irq_pend | input | NSRC | Pending hardware sources, bit 0 highest priority |
| gie | input | 1 | Global interrupt enable of the core |
| skip_pend | input | 1 | Conditional skip not yet resolved |
| pc_cur | input | PC_W | Current word program counter |
| sp_cur | input | SP_W | Current stack pointer |
| busy | output | 1 | Entry in progress |
| st_valid | output | 1 | Stack byte offered |
| st_ready | input | 1 | Memory accepts the byte |
| st_addr | output | SP_W | Stack byte address |
| st_data | output | 8 | Stack byte value |
| sp_we | output | 1 | Stack pointer update strobe |
| sp_next | output | SP_W | New stack pointer value |
| pc_we | output | 1 | Program counter load strobe |
| pc_next | output | PC_W | Vector address |
| gie_clr | output | 1 | Clear the global interrupt enable |
| pend_clr | output | NSRC | One-hot clear of the served source |
| rst_taken | output | 1 | Reset entry completed |

## Verification
A corrupted byte counter shows up at the stream as a push that is one byte too short or too long. The load strobe then appears one transfer early or late, within a few cycles of acceptance. A stale shift register or pointer produces a wrong `st_data` or `st_addr` on the very first or second handshake. A wrong priority or latched vector shows only at the load cycle, as a wrong `pc_next` or `pend_clr`. A state machine stuck outside idle keeps `busy` high and blocks every later entry, which the next directed request exposes.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PUSH = 2'd1,
    SEQ_LOAD = 2'd2
  } seq_state_e;

  function automatic int push_bytes(input int pc_w);
    if (pc_w > 16) return 3;
    else if (pc_w > 8) return 2;
    else return 1;
  endfunction
endpackage

// File: rtl/irq_entry_arb.sv
module irq_entry_arb #(
  parameter int NSRC  = 32,
  parameter int VEC_W = 6
) (
  input  logic             enable,
  input  logic             rst_req,
  input  logic [NSRC-1:0]  pend,
  input  logic             gie,
  input  logic             skip,
  output logic             take,
  output logic             take_rst,
  output logic [VEC_W-1:0] vec,
  output logic [NSRC-1:0]  win_mask
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC:0]     below;
  logic [NSRC-1:0]   first_hot;
  logic [IDX_W-1:0]  idx;
  logic              open_gate;
  logic              take_irq;

  assign below[0] = 1'b0;
  for (genvar g = 0; g < NSRC; g++) begin : g_chain
    assign first_hot[g] = pend[g] & ~below[g];
    assign below[g+1]   = below[g] | pend[g];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NSRC; i++)
      if (first_hot[i]) idx = IDX_W'(i);
  end

  assign open_gate = enable & gie & ~skip;
  assign take_rst  = open_gate & rst_req;
  assign take_irq  = open_gate & ~rst_req & below[NSRC];
  assign take      = take_rst | take_irq;
  assign vec       = take_rst ? '0 : (VEC_W'(idx) + VEC_W'(1));
  assign win_mask  = take_rst ? '0 : first_hot;
endmodule

// File: rtl/irq_entry_stk.sv
module irq_entry_stk #(
  parameter int PC_W   = 22,
  parameter int SP_W   = 16,
  parameter int NBYTES = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [PC_W-1:0] pc_in,
  input  logic [SP_W-1:0] sp_in,
  input  logic            step,
  output logic [7:0]      byte_out,
  output logic [SP_W-1:0] addr_out,
  output logic            last
);
  localparam int SH_W  = NBYTES * 8;
  localparam int CNT_W = $clog2(NBYTES + 1);

  logic [SH_W-1:0]  sh_q;
  logic [SP_W-1:0]  ptr_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      sh_q  <= SH_W'(pc_in);
      ptr_q <= sp_in;
      cnt_q <= '0;
    end else if (step) begin
      sh_q  <= sh_q >> 8;
      ptr_q <= ptr_q - SP_W'(1);
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign byte_out = sh_q[7:0];
  assign addr_out = ptr_q;
  assign last     = (cnt_q == CNT_W'(NBYTES - 1));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int NSRC     = 32,
  parameter int PC_W     = 22,
  parameter int SP_W     = 16,
  parameter bit LONG_VEC = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rst_req,
  input  logic [NSRC-1:0] irq_pend,
  input  logic            gie,
  input  logic            skip_pend,
  input  logic [PC_W-1:0] pc_cur,
  input  logic [SP_W-1:0] sp_cur,
  output logic            busy,
  output logic            st_valid,
  input  logic            st_ready,
  output logic [SP_W-1:0] st_addr,
  output logic [7:0]      st_data,
  output logic            sp_we,
  output logic [SP_W-1:0] sp_next,
  output logic            pc_we,
  output logic [PC_W-1:0] pc_next,
  output logic            gie_clr,
  output logic [NSRC-1:0] pend_clr,
  output logic            rst_taken
);
  localparam int NBYTES  = push_bytes(PC_W);
  localparam int VEC_W   = $clog2(NSRC + 1);
  localparam int LOG_VSZ = LONG_VEC ? 1 : 0;

  seq_state_e        state_q;
  logic              take, take_rst, hs, last;
  logic [VEC_W-1:0]  vec_w, vec_q;
  logic [NSRC-1:0]   mask_w, mask_q;
  logic              rst_q;
  logic              idle;

  assign idle = (state_q == SEQ_IDLE);

  irq_entry_arb #(.NSRC(NSRC), .VEC_W(VEC_W)) u_arb (
    .enable   (idle),
    .rst_req  (rst_req),
    .pend     (irq_pend),
    .gie      (gie),
    .skip     (skip_pend),
    .take     (take),
    .take_rst (take_rst),
    .vec      (vec_w),
    .win_mask (mask_w)
  );

  irq_entry_stk #(.PC_W(PC_W), .SP_W(SP_W), .NBYTES(NBYTES)) u_stk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (take),
    .pc_in    (pc_cur),
    .sp_in    (sp_cur),
    .step     (hs),
    .byte_out (st_data),
    .addr_out (st_addr),
    .last     (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      vec_q   <= '0;
      mask_q  <= '0;
      rst_q   <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (take) begin
          state_q <= SEQ_PUSH;
          vec_q   <= vec_w;
          mask_q  <= mask_w;
          rst_q   <= take_rst;
        end
        SEQ_PUSH: if (hs && last) state_q <= SEQ_LOAD;
        SEQ_LOAD: state_q <= SEQ_IDLE;
        default:  state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy      = ~idle;
  assign st_valid  = (state_q == SEQ_PUSH);
  assign hs        = st_valid & st_ready;
  assign sp_we     = hs;
  assign sp_next   = st_addr - SP_W'(1);
  assign pc_we     = (state_q == SEQ_LOAD);
  assign pc_next   = PC_W'(vec_q) << LOG_VSZ;
  assign gie_clr   = pc_we;
  assign pend_clr  = pc_we ? mask_q : '0;
  assign rst_taken = pc_we & rst_q;
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int NSRC = 32,
  parameter int PC_W = 22,
  parameter int SP_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            gie,
  input logic            skip_pend,
  input logic            busy,
  input logic            st_valid,
  input logic            st_ready,
  input logic [SP_W-1:0] st_addr,
  input logic [7:0]      st_data,
  input logic            sp_we,
  input logic            pc_we,
  input logic [PC_W-1:0] pc_next,
  input logic            gie_clr,
  input logic [NSRC-1:0] pend_clr,
  input logic            rst_taken
);
  // R2
  skip_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && skip_pend) |=> !busy);
  // R3
  gie_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !gie) |=> !busy);
  // R4
  rst_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_taken |-> (pc_we && pc_next == '0 && pend_clr == '0));
  // R5
  one_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pend_clr));
  // R7
  sp_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |-> (st_valid && st_ready));
  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_addr) && $stable(st_data)));
  // R9
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid || pc_we) |-> busy);
  // R9
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |=> !busy);
  // R10
  load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> (gie_clr && !st_valid) ##1 !pc_we);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.NSRC(NSRC), .PC_W(PC_W), .SP_W(SP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .gie       (gie),
  .skip_pend (skip_pend),
  .busy      (busy),
  .st_valid  (st_valid),
  .st_ready  (st_ready),
  .st_addr   (st_addr),
  .st_data   (st_data),
  .sp_we     (sp_we),
  .pc_we     (pc_we),
  .pc_next   (pc_next),
  .gie_clr   (gie_clr),
  .pend_clr  (pend_clr),
  .rst_taken (rst_taken)
);

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
  localparam int NSRC = 32;
  localparam int PC_W = 22;
  localparam int SP_W = 16;
  localparam int NB   = 3;   // R6: PC_W above 16

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            rst_req = 1'b0;
  logic [NSRC-1:0] irq_pend = '0;
  logic            gie = 1'b0;
  logic            skip_pend = 1'b0;
  logic [PC_W-1:0] pc_cur = '0;
  logic [SP_W-1:0] sp_cur = '0;
  logic            st_ready = 1'b0;
  logic            busy, st_valid, sp_we, pc_we, gie_clr, rst_taken;
  logic [SP_W-1:0] st_addr, sp_next;
  logic [7:0]      st_data;
  logic [PC_W-1:0] pc_next;
  logic [NSRC-1:0] pend_clr;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #10 clk = ~clk;

  irq_entry_seq u_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .irq_pend(irq_pend),
    .gie(gie), .skip_pend(skip_pend), .pc_cur(pc_cur), .sp_cur(sp_cur),
    .busy(busy), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .sp_we(sp_we), .sp_next(sp_next),
    .pc_we(pc_we), .pc_next(pc_next), .gie_clr(gie_clr),
    .pend_clr(pend_clr), .rst_taken(rst_taken)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lowest_bit(input logic [NSRC-1:0] v);
    for (int i = 0; i < NSRC; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic idle_window(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      check(!busy && !st_valid && !pc_we, req, {busy, st_valid, pc_we}, 0);
    end
  endtask

  // One accepted entry; stall_pct is the chance (in %) of st_ready low.
  task automatic do_entry(input logic rq, input logic [NSRC-1:0] pd,
                          input logic [PC_W-1:0] pc, input logic [SP_W-1:0] sp,
                          input int stall_pct, input bit disturb);
    int              win;
    logic [PC_W-1:0] exp_pc;
    logic [NSRC-1:0] exp_mask;
    logic [23:0]     pcx;
    int              nb;
    bit              done, first, prev_stall, prev_last;
    logic [SP_W-1:0] pa;
    logic [7:0]      pdat;
    win      = lowest_bit(pd);
    exp_pc   = rq ? '0 : PC_W'((win + 1) * 2);
    exp_mask = rq ? '0 : (NSRC'(1) << win);
    pcx      = 24'(pc);
    @(negedge clk);
    rst_req = rq; irq_pend = pd; pc_cur = pc; sp_cur = sp; gie = 1'b1; skip_pend = 1'b0;
    st_ready = ($urandom % 100) >= stall_pct;
    @(posedge clk);
    nb = 0; done = 0; first = 1; prev_stall = 0; prev_last = 0; pa = '0; pdat = '0;
    for (int t = 0; t < 200 && !done; t++) begin
      @(negedge clk);
      if (disturb) begin
        rst_req = ~rq; irq_pend = irq_pend | NSRC'(1); pc_cur = ~pc; sp_cur = ~sp;
      end
      st_ready = ($urandom % 100) >= stall_pct;
      #1;
      check(busy, "R9", busy, 1);
      if (first) check(st_valid, "R11", st_valid, 1);
      first = 0;
      if (st_valid) begin
        check(!prev_last, "R6", nb, NB);
        if (prev_stall) check(st_addr == pa && st_data == pdat, "R8", {st_addr, st_data}, {pa, pdat});
        if (st_ready) begin
          check(st_addr == sp - SP_W'(nb), "R6", st_addr, sp - SP_W'(nb));
          check(st_data == pcx[8*nb +: 8], "R6", st_data, pcx[8*nb +: 8]);
          check(sp_we && sp_next == st_addr - SP_W'(1), "R7", sp_next, st_addr - SP_W'(1));
          nb++;
          prev_last = (nb == NB);
        end else begin
          check(!sp_we, "R8", sp_we, 0);
          prev_last = 0;
        end
        prev_stall = !st_ready; pa = st_addr; pdat = st_data;
      end else begin
        check(pc_we, "R10", pc_we, 1);
        check(prev_last && nb == NB, "R11", nb, NB);
        check(pc_next == exp_pc, rq ? "R4" : "R5", pc_next, exp_pc);
        check(pend_clr == exp_mask, rq ? "R4" : "R5", pend_clr, exp_mask);
        check(rst_taken == rq, "R4", rst_taken, rq);
        check(gie_clr, "R10", gie_clr, 1);
        done = 1;
      end
    end
    if (!done) check(0, "R10", 0, 1);
    gie = 1'b0; rst_req = 1'b0; irq_pend = pd & ~exp_mask;
    @(negedge clk); #1;
    check(!busy && !pc_we, "R9", {busy, pc_we}, 0);
  endtask

  initial begin
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    check(0, "watchdog", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    // R1
    check(!busy && !st_valid && !pc_we && !sp_we && !gie_clr && !rst_taken && pend_clr == '0,
          "R1", {busy, st_valid, pc_we}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(!busy && !st_valid, "R1", busy, 0);

    // R3: enable low blocks both kinds
    rst_req = 1'b1; irq_pend = 32'h10; gie = 1'b0;
    idle_window(4, "R3");
    // R3: no pending, no reset
    rst_req = 1'b0; irq_pend = '0; gie = 1'b1;
    idle_window(4, "R3");
    // R2: skip blocks
    rst_req = 1'b1; irq_pend = 32'hF0; skip_pend = 1'b1;
    idle_window(5, "R2");
    skip_pend = 1'b0; gie = 1'b0; rst_req = 1'b0;

    // R4: reset over pending sources
    do_entry(1'b1, 32'h0000_0006, 22'h2A_BCDE, 16'h08FF, 0, 0);
    // R5: single high source, boundary index
    do_entry(1'b0, 32'h8000_0000, 22'h3F_FFFF, 16'h0002, 0, 0);
    // R5: lowest source
    do_entry(1'b0, 32'hFFFF_FFFF, 22'h00_0001, 16'h0000, 0, 0);
    // R8: heavy back-pressure
    do_entry(1'b0, 32'h0001_0100, 22'h15_5AA5, 16'h1234, 80, 0);
    // R9: request changes during entry are ignored
    do_entry(1'b0, 32'h0000_0800, 22'h12_3456, 16'h7FF0, 30, 1);

    // random mix
    for (int r = 0; r < 60; r++) begin
      logic [NSRC-1:0] pd;
      logic            rq;
      pd = $urandom & $urandom & $urandom;
      if (pd == '0) pd = NSRC'(1) << ($urandom % NSRC);
      rq = ($urandom % 5) == 0;
      do_entry(rq, pd, PC_W'($urandom), SP_W'($urandom), $urandom % 60, ($urandom % 4) == 0);
    end

    // R2: skip drop then acceptance
    @(negedge clk);
    irq_pend = 32'h4; gie = 1'b1; skip_pend = 1'b1;
    idle_window(2, "R2");
    skip_pend = 1'b0; gie = 1'b0;
    do_entry(1'b0, 32'h4, 22'h01_0203, 16'h0100, 0, 0);
    idle_window(3, "R10");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule